// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides who owns a shared external memory bus: the processor core or an outside master. The outside master asks for the bus on an active-low request pin. The core reports two things: whether an external access is on the bus in the current cycle, and whether it has an external access waiting to be issued. From these inputs the arbiter drives four outputs. The first is an active-low grant. The second is a drive enable for the address, data, strobe and select pins; when it is low, those pins float. The third is a stall that holds the core. The fourth is a hung flag, raised when the core is waiting on a bus it has given away.

The request pin is not synchronous to the block clock, so it passes through a chain of flops first. The arbiter never takes the bus from an access that is in flight. It does not wait for an instruction to end, so a grant can fall into the idle cycle between two accesses of the same instruction. In go mode the core keeps running while the bus is granted away and stops only when it needs the bus itself.

The arbiter has its own reset. It keeps serving requests while the core is held in reset or is booting.

Top module: `busGrantCtl`

## Requirements
- R1: After `rstN` is asserted, `busGrantN` is 1, `busOe` is 1, and `coreStall` and `busHung` are 0, whatever `busReqN` is doing.
- R2: `busReqN` passes through a two-stage synchronizer. Suppose `busReqN` goes low before clock edge n and no access is in progress. Then `busGrantN` goes low after edge n+2 and not earlier.
- R3: While `accBusy` is 1 (with `coreRstN` = 1), the grant is not asserted. It is asserted at the first clock edge at which `accBusy` is 0 and the synchronized request is active.
- R4: `busOe` is the complement of the grant state: `busOe` always equals `busGrantN`, and both change on the same clock edge.
- R5: With `goMode` = 0, `coreStall` is 1 in every cycle in which the grant is asserted.
- R6: With `goMode` = 1, while the grant is asserted, `coreStall` equals `accNeed`.
- R7: `busHung` is 1 exactly when the grant is asserted, `accNeed` is 1 and `coreRstN` is 1.
- R8: Suppose `busReqN` returns high before edge n. Then `busGrantN` returns to 1, `busOe` to 1, and `coreStall` and `busHung` to 0 after edge n+2.
- R9: Consider an idle cycle (`accBusy` = 0, `accNeed` = 1) between two accesses of one instruction. If the request is active during that cycle, the grant is given at its closing edge.
- R10: While `coreRstN` is 0, `accBusy` and `accNeed` are ignored, so requests are granted with the R2 timing even if `accBusy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Arbiter reset, asynchronous assert, active low |
| coreRstN | input | 1 | Core reset state, active low; masks the access inputs |
| busReqN | input | 1 | Bus request from outside master, active low, asynchronous |
| goMode | input | 1 | 1 = core keeps running while bus is granted away |
| accBusy | input | 1 | Core external access occupies the bus this cycle |
| accNeed | input | 1 | Core has an external access waiting to issue |
| busGrantN | output | 1 | Bus grant, active low |
| busOe | output | 1 | Drive enable for address, data, strobe and select pins (0 = float) |
| coreStall | output | 1 | Hold the core |
| busHung | output | 1 | Core needs the bus but it is granted away |

## Verification
The assertions run on every cycle and cover several invariants:
- the drive enable always follows the grant;
- no grant is taken while an access holds the bus;
- an inactive request never grants and an active one is released when it goes inactive;
- the stall and hung outputs never rise without a grant, with go mode's exception for stall.

Some behaviour only the bench scenarios can show. These are the exact synchronizer latency on assertion and release, and a grant landing in the one-cycle gap between two accesses. They also include the masking of a busy access while the core is in reset, and a return to the idle state when the arbiter reset hits in the middle of a grant.

// File: rtl/busArbPkg.sv
package busArbPkg;
  // strobes from control to the grant/enable registers
  typedef struct packed {
    logic grantSet;
    logic grantClr;
  } arbStrobeT;
endpackage

// File: rtl/busReqSync.sv
module busReqSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqPinN,
  output logic reqActive
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chainQ;

  // first stage samples the pin, later stages follow the previous one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ[0] <= 1'b1;
    else       chainQ[0] <= reqPinN;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ[s] <= 1'b1;
      else       chainQ[s] <= chainQ[s-1];
    end
  end

  assign reqActive = ~chainQ[LAST];
endmodule

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqActive,
  input  logic      grantQ,
  input  logic      coreRstN,
  input  logic      goMode,
  input  logic      accBusy,
  input  logic      accNeed,
  output arbStrobeT strobe,
  output logic      coreStall,
  output logic      busHung
);
  logic busyEff;
  logic needEff;

  // a core held in reset performs no external access
  assign busyEff = accBusy & coreRstN;
  assign needEff = accNeed & coreRstN;

  always_comb begin
    strobe          = '0;
    strobe.grantSet = !grantQ && reqActive && !busyEff;
    strobe.grantClr = grantQ && !reqActive;
  end

  assign coreStall = grantQ && (!goMode || needEff);
  assign busHung   = grantQ && needEff;

  AST_NO_GRANT_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (!grantQ && busyEff) |=> !grantQ); // R3
  AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!grantQ && !reqActive) |=> !grantQ); // R2
  AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ && !reqActive) |=> !grantQ); // R8
  AST_HALT_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ && !goMode) |-> coreStall); // R5
  AST_STALL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    coreStall |-> grantQ); // R6
  AST_HUNG_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    busHung |-> (grantQ && accNeed && coreRstN)); // R7
endmodule

// File: rtl/busArbDp.sv
module busArbDp
  import busArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  arbStrobeT strobe,
  output logic      grantQ,
  output logic      oeQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                grantQ <= 1'b0;
    else if (strobe.grantSet) grantQ <= 1'b1;
    else if (strobe.grantClr) grantQ <= 1'b0;
  end

  // separate enable flop, updated by the same strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                oeQ <= 1'b1;
    else if (strobe.grantSet) oeQ <= 1'b0;
    else if (strobe.grantClr) oeQ <= 1'b1;
  end
endmodule

// File: rtl/busGrantCtl.sv
module busGrantCtl
  import busArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic coreRstN,
  input  logic busReqN,
  input  logic goMode,
  input  logic accBusy,
  input  logic accNeed,
  output logic busGrantN,
  output logic busOe,
  output logic coreStall,
  output logic busHung
);
  logic      reqActive;
  logic      grantQ;
  logic      oeQ;
  arbStrobeT strobe;

  busReqSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rstN      (rstN),
    .reqPinN   (busReqN),
    .reqActive (reqActive)
  );

  busArbCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqActive (reqActive),
    .grantQ    (grantQ),
    .coreRstN  (coreRstN),
    .goMode    (goMode),
    .accBusy   (accBusy),
    .accNeed   (accNeed),
    .strobe    (strobe),
    .coreStall (coreStall),
    .busHung   (busHung)
  );

  busArbDp i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .grantQ (grantQ),
    .oeQ    (oeQ)
  );

  assign busGrantN = ~grantQ;
  assign busOe     = oeQ;

  AST_OE_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    busOe == busGrantN); // R4
endmodule

// File: tb/test_busGrantCtl.sv
module test_busGrantCtl;
  logic clk = 1'b0;
  logic rstN, coreRstN, busReqN, goMode, accBusy, accNeed;
  logic busGrantN, busOe, coreStall, busHung;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  busGrantCtl i_busGrantCtl (
    .clk(clk), .rstN(rstN), .coreRstN(coreRstN), .busReqN(busReqN),
    .goMode(goMode), .accBusy(accBusy), .accNeed(accNeed),
    .busGrantN(busGrantN), .busOe(busOe), .coreStall(coreStall), .busHung(busHung)
  );

  // {reqN, go, busy, need, coreRstN} {expGrantN, expStall, expHung} requirement
  localparam int NV = 39;
  localparam logic [11:0] VEC [NV] = '{
    {5'b10001, 3'b100, 4'd1},  // idle
    {5'b00001, 3'b100, 4'd2},  // R2 request low
    {5'b00001, 3'b100, 4'd2},  // R2 still syncing
    {5'b00001, 3'b010, 4'd2},  // R2 granted, R5 stall
    {5'b00011, 3'b011, 4'd7},  // R7 hung
    {5'b10011, 3'b011, 4'd8},  // R8 release syncing
    {5'b10011, 3'b011, 4'd8},
    {5'b10011, 3'b100, 4'd8},  // R8 released
    {5'b10101, 3'b100, 4'd3},  // R3 access
    {5'b00101, 3'b100, 4'd3},
    {5'b00101, 3'b100, 4'd3},
    {5'b00101, 3'b100, 4'd3},  // R3 request ready, access holds
    {5'b00101, 3'b100, 4'd3},
    {5'b00001, 3'b010, 4'd3},  // R3 grant after access ends
    {5'b10001, 3'b010, 4'd5},
    {5'b10001, 3'b010, 4'd5},
    {5'b10001, 3'b100, 4'd8},
    {5'b01001, 3'b100, 4'd6},  // R6 go mode
    {5'b01001, 3'b100, 4'd6},
    {5'b01001, 3'b000, 4'd6},  // R6 granted, core runs
    {5'b01011, 3'b011, 4'd6},  // R6 needs bus
    {5'b11011, 3'b011, 4'd7},
    {5'b11001, 3'b000, 4'd6},
    {5'b11001, 3'b100, 4'd8},
    {5'b10111, 3'b100, 4'd9},  // R9 first access
    {5'b00111, 3'b100, 4'd9},
    {5'b00111, 3'b100, 4'd9},
    {5'b00111, 3'b100, 4'd9},
    {5'b00011, 3'b011, 4'd9},  // R9 grant in the gap
    {5'b10011, 3'b011, 4'd9},
    {5'b10011, 3'b011, 4'd9},
    {5'b10011, 3'b100, 4'd8},
    {5'b10110, 3'b100, 4'd10}, // second access, then core reset
    {5'b00100, 3'b100, 4'd10}, // R10
    {5'b00100, 3'b100, 4'd10},
    {5'b00100, 3'b010, 4'd10}, // R10 busy ignored
    {5'b10001, 3'b010, 4'd10},
    {5'b10001, 3'b010, 4'd10},
    {5'b10001, 3'b100, 4'd8}
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic eg, input logic es, input logic eh);
    check(req, "busGrantN", busGrantN, eg);
    check("R4", "busOe", busOe, eg);
    check(req, "coreStall", coreStall, es);
    check(req, "busHung", busHung, eh);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; coreRstN = 1'b0; busReqN = 1'b0; goMode = 1'b0;
    accBusy = 1'b0; accNeed = 1'b0;
    repeat (4) @(posedge clk);
    #1 checkAll("R1", 1'b1, 1'b0, 1'b0);  // R1 request ignored in reset
    @(negedge clk);
    rstN = 1'b1; coreRstN = 1'b1; busReqN = 1'b1;
    repeat (3) @(posedge clk);

    for (int j = 0; j < NV; j++) begin
      @(negedge clk);
      {busReqN, goMode, accBusy, accNeed, coreRstN} = VEC[j][11:7];
      @(posedge clk);
      #1 checkAll($sformatf("R%0d step %0d", VEC[j][3:0], j),
                  VEC[j][6], VEC[j][5], VEC[j][4]);
    end

    // R1 mid-grant reset
    @(negedge clk);
    busReqN = 1'b0; goMode = 1'b0; accBusy = 1'b0; accNeed = 1'b1; coreRstN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkAll("R2", 1'b0, 1'b1, 1'b1);
    @(negedge clk) rstN = 1'b0;
    #1 checkAll("R1", 1'b1, 1'b0, 1'b0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1 checkAll("R2", 1'b1, 1'b0, 1'b0);  // sync refilling, no early grant
    @(posedge clk);
    @(posedge clk);
    #1 checkAll("R2", 1'b0, 1'b1, 1'b1);
    @(negedge clk) busReqN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkAll("R8", 1'b1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule